// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides whether a memory access to a page that has already been translated may go ahead. The core presents the virtual address and the direction of the access. It also presents its privilege level, two global protection control bits and the 32-bit domain access control word. The translation entry supplies its domain number, its permission byte and its mapping kind. From these the block returns a fault code in the same cycle. The fault code says either that the access is allowed, or which kind of fault it raises.

Each entry belongs to one of sixteen domains. A 2-bit access field per domain decides whether accesses in that domain fault outright, skip checking, or are checked against the entry's permissions. Pages are split into four subpages, and each subpage has its own 2-bit permission code. The subpage is chosen by address bits, and which address bits are used depends on the page size. On every valid check, the block also registers the domain of the entry. Fault handling reads this value later.

Top module: `dom_perm_check`

## Requirements
- R1: The access field for an entry is the 2-bit slice `domainCtl[2*entDomain+1 : 2*entDomain]`.
- R2: With `chkValid` high and an access field of 0 or 2, `faultCode` is 1 (domain fault). This holds for every mapping kind and every permission setting.
- R3: With `chkValid` high and an access field of 3, `faultCode` is 0, whatever the permissions, direction and privilege.
- R4: With an access field of 1, the 2-bit permission code is `entPerms[2*s+5 : 2*s+4]`. The subpage `s` depends on `entKind` (1 small, 2 large, 3 section, 4 extended small, 5 tiny, 0 invalid). It is `vaddr[11:10]` for kind 1, `vaddr[15:14]` for kind 2, 3 for kind 3, and 0 for every other kind.
- R5: Permission code 0 allows only reads. A read is allowed when `romProt` is 1, or when `sysProt` is 1 and `isUser` is 0.
- R6: Permission code 1 allows any access with `isUser` 0 and none with `isUser` 1. Code 2 allows every read, and allows writes only with `isUser` 0. Code 3 allows every access.
- R7: When the permission code refuses an access, `faultCode` is 2 (section permission fault) if `entKind` is 3, and 3 (subpage permission fault) for every other kind.
- R8: `lastDomain` takes `entDomain` at the rising clock edge of every cycle with `chkValid` high. It holds otherwise, and it is 0 after reset.
- R9: With `chkValid` low, `faultCode` is 0 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chkValid | input | 1 | A check is requested this cycle |
| vaddr | input | 32 | Virtual address of the access |
| isRead | input | 1 | 1 for a read, 0 for a write |
| isUser | input | 1 | 1 when the core runs with user-level rights |
| sysProt | input | 1 | System protection control bit |
| romProt | input | 1 | ROM protection control bit |
| domainCtl | input | 32 | Domain access control word, 2 bits per domain |
| entDomain | input | 4 | Domain number of the entry |
| entPerms | input | 12 | Entry permission bits; bits 11:4 hold four 2-bit subpage codes |
| entKind | input | 3 | Mapping kind of the entry |
| faultCode | output | 2 | 0 none, 1 domain, 2 section permission, 3 subpage permission |
| lastDomain | output | 4 | Domain of the most recent valid check |

## Verification
The fault code comes from combinational logic, so it is due in the same cycle as its inputs. The bench drives each stimulus on a falling edge and reads `faultCode` 5 ns later, well before the next rising edge. `lastDomain` is due one rising edge after the check, so the monitor reads it 2 ns after that edge. The scoreboard item holds the expected domain for that edge, so every item pairs a same-cycle fault check with a next-edge domain check.

// File: rtl/dom_perm_pkg.sv
package dom_perm_pkg;

  typedef enum logic [2:0] {
    KIND_NONE     = 3'd0,
    KIND_SMALL    = 3'd1,
    KIND_LARGE    = 3'd2,
    KIND_SECTION  = 3'd3,
    KIND_EXTSMALL = 3'd4,
    KIND_TINY     = 3'd5
  } mapKind_e;

  typedef enum logic [1:0] {
    FLT_NONE       = 2'd0,
    FLT_SEC_DOMAIN = 2'd1,
    FLT_SEC_PERM   = 2'd2,
    FLT_SUB_PERM   = 2'd3
  } fault_e;

  localparam logic [1:0] ACC_DENY    = 2'd0;
  localparam logic [1:0] ACC_CLIENT  = 2'd1;
  localparam logic [1:0] ACC_RESV    = 2'd2;
  localparam logic [1:0] ACC_MANAGER = 2'd3;

  localparam int SUB_W   = 2;
  localparam int NUM_SUB = 1 << SUB_W;

  typedef struct packed {
    logic domFault;
    logic permCheck;
    logic recordDom;
  } ctlStrobe_t;

endpackage

// File: rtl/dom_perm_ctl.sv
module dom_perm_ctl
  import dom_perm_pkg::*;
#(
  parameter int DOM_W = 4
) (
  input  logic                        chkValid,
  input  logic [2*(1<<DOM_W)-1:0]     domainCtl,
  input  logic [DOM_W-1:0]            entDomain,
  output ctlStrobe_t                  strobe
);

  localparam int NUM_DOM = 1 << DOM_W;

  logic [1:0] fieldArr [NUM_DOM];
  logic [1:0] accField;

  for (genvar gi = 0; gi < NUM_DOM; gi++) begin : g_field
    assign fieldArr[gi] = domainCtl[2*gi +: 2];
  end

  assign accField = fieldArr[entDomain];

  always_comb begin
    strobe = '0;
    strobe.recordDom = chkValid;
    if (chkValid) begin
      case (accField)
        ACC_DENY, ACC_RESV: strobe.domFault  = 1'b1;
        ACC_CLIENT:         strobe.permCheck = 1'b1;
        default:            ;
      endcase
    end
  end

endmodule

// File: rtl/dom_perm_dp.sv
module dom_perm_dp
  import dom_perm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DOM_W     = 4,
  parameter int SMALL_LSB = 10,
  parameter int LARGE_LSB = 14,
  parameter int AP_LSB    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             vaddr,
  input  logic                          isRead,
  input  logic                          isUser,
  input  logic                          sysProt,
  input  logic                          romProt,
  input  logic [DOM_W-1:0]              entDomain,
  input  logic [AP_LSB+2*NUM_SUB-1:0]   entPerms,
  input  logic [2:0]                    entKind,
  output logic [1:0]                    faultCode,
  output logic [DOM_W-1:0]              lastDomain
);

  localparam int PERM_W = AP_LSB + 2*NUM_SUB;
  localparam logic [ADDR_W-1:0] ADDR_USED =
    (ADDR_W'(3) << SMALL_LSB) | (ADDR_W'(3) << LARGE_LSB);
  localparam logic [PERM_W-1:0] PERM_LOW = PERM_W'((1 << AP_LSB) - 1);

  mapKind_e   kind;
  logic [SUB_W-1:0] subIdx;
  logic [1:0] apArr [NUM_SUB];
  logic [1:0] apSel;
  logic       permOk;
  fault_e     fault;
  logic       unusedAddr;
  logic       unusedPerm;

  assign kind       = mapKind_e'(entKind);
  assign unusedAddr = ^(vaddr & ~ADDR_USED);
  assign unusedPerm = ^(entPerms & PERM_LOW);

  // subpage selection depends on the page size
  always_comb begin
    case (kind)
      KIND_SMALL:   subIdx = vaddr[SMALL_LSB +: SUB_W];
      KIND_LARGE:   subIdx = vaddr[LARGE_LSB +: SUB_W];
      KIND_SECTION: subIdx = SUB_W'(NUM_SUB - 1);
      default:      subIdx = '0;
    endcase
  end

  for (genvar gs = 0; gs < NUM_SUB; gs++) begin : g_ap
    assign apArr[gs] = entPerms[AP_LSB + 2*gs +: 2];
  end

  assign apSel = apArr[subIdx];

  always_comb begin
    case (apSel)
      2'd0:    permOk = isRead && ((sysProt && !isUser) || romProt);
      2'd1:    permOk = !isUser;
      2'd2:    permOk = isRead || !isUser;
      default: permOk = 1'b1;
    endcase
  end

  always_comb begin
    fault = FLT_NONE;
    if (strobe.domFault)
      fault = FLT_SEC_DOMAIN;
    else if (strobe.permCheck && !permOk)
      fault = (kind == KIND_SECTION) ? FLT_SEC_PERM : FLT_SUB_PERM;
  end

  assign faultCode = fault;

  always_ff @(posedge clk) begin
    if (!rstN)
      lastDomain <= '0;
    else if (strobe.recordDom)
      lastDomain <= entDomain;
  end

  p_open_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.permCheck && apSel == 2'd3) |-> faultCode == 2'd0);

  p_sec_perm_kind_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode == 2'd2) |-> (entKind == 3'd3));

  p_last_take_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recordDom |=> lastDomain == $past(entDomain));

  p_last_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.recordDom |=> $stable(lastDomain));

endmodule

// File: rtl/dom_perm_check.sv
module dom_perm_check
  import dom_perm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DOM_W     = 4,
  parameter int SMALL_LSB = 10,
  parameter int LARGE_LSB = 14,
  parameter int AP_LSB    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          chkValid,
  input  logic [ADDR_W-1:0]             vaddr,
  input  logic                          isRead,
  input  logic                          isUser,
  input  logic                          sysProt,
  input  logic                          romProt,
  input  logic [2*(1<<DOM_W)-1:0]       domainCtl,
  input  logic [DOM_W-1:0]              entDomain,
  input  logic [AP_LSB+2*NUM_SUB-1:0]   entPerms,
  input  logic [2:0]                    entKind,
  output logic [1:0]                    faultCode,
  output logic [DOM_W-1:0]              lastDomain
);

  ctlStrobe_t strobe;
  logic [1:0] portField;

  dom_perm_ctl #(.DOM_W(DOM_W)) u_ctl (
    .chkValid  (chkValid),
    .domainCtl (domainCtl),
    .entDomain (entDomain),
    .strobe    (strobe)
  );

  dom_perm_dp #(
    .ADDR_W(ADDR_W), .DOM_W(DOM_W), .SMALL_LSB(SMALL_LSB),
    .LARGE_LSB(LARGE_LSB), .AP_LSB(AP_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .vaddr      (vaddr),
    .isRead     (isRead),
    .isUser     (isUser),
    .sysProt    (sysProt),
    .romProt    (romProt),
    .entDomain  (entDomain),
    .entPerms   (entPerms),
    .entKind    (entKind),
    .faultCode  (faultCode),
    .lastDomain (lastDomain)
  );

  assign portField = domainCtl[2*entDomain +: 2];

  p_dom_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && (portField == 2'd0 || portField == 2'd2)) |-> faultCode == 2'd1);

  p_manager_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && portField == 2'd3) |-> faultCode == 2'd0);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> faultCode == 2'd0);

endmodule

// File: tb/dom_perm_check_test.sv
module dom_perm_check_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chkValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        isRead = 1'b0;
  logic        isUser = 1'b0;
  logic        sysProt = 1'b0;
  logic        romProt = 1'b0;
  logic [31:0] domainCtl = '0;
  logic [3:0]  entDomain = '0;
  logic [11:0] entPerms = '0;
  logic [2:0]  entKind = '0;
  logic [1:0]  faultCode;
  logic [3:0]  lastDomain;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [3:0] expLast = '0;

  typedef struct {
    logic [1:0] fault;
    logic [3:0] dom;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #10 clk = ~clk;

  dom_perm_check uut (
    .clk(clk), .rstN(rstN), .chkValid(chkValid), .vaddr(vaddr),
    .isRead(isRead), .isUser(isUser), .sysProt(sysProt), .romProt(romProt),
    .domainCtl(domainCtl), .entDomain(entDomain), .entPerms(entPerms),
    .entKind(entKind), .faultCode(faultCode), .lastDomain(lastDomain)
  );

  function automatic logic [1:0] refFault(
    input logic v, input logic [31:0] a, input logic rd, input logic usr,
    input logic sys, input logic rom, input logic [31:0] dac,
    input logic [3:0] dom, input logic [11:0] pm, input logic [2:0] kd);
    logic [1:0] fld, sub, ap;
    logic ok;
    if (!v) return 2'd0;
    fld = 2'((dac >> (dom * 2)) & 32'd3);
    if (fld == 2'd0 || fld == 2'd2) return 2'd1;
    if (fld == 2'd3) return 2'd0;
    if (kd == 3'd1)      sub = a[11:10];
    else if (kd == 3'd2) sub = a[15:14];
    else if (kd == 3'd3) sub = 2'd3;
    else                 sub = 2'd0;
    ap = 2'((pm >> (4 + 2 * sub)) & 12'd3);
    if (ap == 2'd0)      ok = rd && ((sys && !usr) || rom);
    else if (ap == 2'd1) ok = !usr;
    else if (ap == 2'd2) ok = rd || !usr;
    else                 ok = 1'b1;
    if (ok) return 2'd0;
    return (kd == 3'd3) ? 2'd2 : 2'd3;
  endfunction

  task automatic drive(input logic v, input logic [31:0] a, input logic rd,
                       input logic usr, input logic sys, input logic rom,
                       input logic [31:0] dac, input logic [3:0] dom,
                       input logic [11:0] pm, input logic [2:0] kd,
                       input string tag);
    item_t it;
    @(negedge clk);
    chkValid = v; vaddr = a; isRead = rd; isUser = usr; sysProt = sys;
    romProt = rom; domainCtl = dac; entDomain = dom; entPerms = pm; entKind = kd;
    if (v) expLast = dom;
    it.fault = refFault(v, a, rd, usr, sys, rom, dac, dom, pm, kd);
    it.dom   = expLast;
    it.tag   = tag;
    sbq.push_back(it);
  endtask

  // monitor: fault same cycle, last domain after the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checkCnt++;
        if (faultCode !== it.fault) begin
          failCnt++;
          $display("FAIL %s faultCode actual=%0d expected=%0d", it.tag, faultCode, it.fault);
        end
        @(posedge clk);
        #2;
        checkCnt++;
        if (lastDomain !== it.dom) begin
          failCnt++;
          $display("FAIL R8 (%s) lastDomain actual=%0d expected=%0d", it.tag, lastDomain, it.dom);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  localparam logic [11:0] MIX = 12'hE40; // sub0 code0, sub1 code1, sub2 code2, sub3 code3

  initial begin
    repeat (3) @(negedge clk);
    checkCnt++;
    if (lastDomain !== 4'd0 || faultCode !== 2'd0) begin
      failCnt++;
      $display("FAIL R8 reset actual=%0d/%0d expected=0/0", lastDomain, faultCode);
    end
    rstN = 1'b1;

    // R1 field selection
    drive(1, 0, 0, 1, 0, 0, 32'h0000_0C00, 4'd5, 12'h000, 3'd1, "R1");
    drive(1, 0, 0, 1, 0, 0, 32'h0000_0C00, 4'd4, 12'h000, 3'd1, "R1");
    drive(1, 0, 0, 1, 0, 0, 32'hC000_0000, 4'd15, 12'h000, 3'd1, "R1");
    drive(1, 0, 0, 1, 0, 0, 32'hC000_0000, 4'd14, 12'h000, 3'd1, "R1");
    // R2 deny and reserved fields
    drive(1, 0, 1, 0, 1, 1, 32'h0000_0020, 4'd2, 12'hFFF, 3'd3, "R2");
    drive(1, 0, 1, 0, 1, 1, 32'h0000_0000, 4'd7, 12'hFFF, 3'd5, "R2");
    drive(1, 0, 1, 0, 1, 1, 32'h0000_0020, 4'd2, 12'hFFF, 3'd1, "R2");
    // R3 manager skips permissions
    drive(1, 0, 0, 1, 0, 0, 32'h0000_0030, 4'd2, 12'h000, 3'd3, "R3");
    drive(1, 0, 0, 1, 0, 0, 32'h0000_0030, 4'd2, 12'h000, 3'd5, "R3");
    // R4 small page subpages
    drive(1, 32'h0000_0000, 1, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd1, "R4");
    drive(1, 32'h0000_0400, 1, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd1, "R4");
    drive(1, 32'h0000_0800, 1, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd1, "R4");
    drive(1, 32'h0000_0C00, 0, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd1, "R4");
    // R4 large page subpages
    drive(1, 32'h0000_4000, 1, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd2, "R4");
    drive(1, 32'h0000_8000, 1, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd2, "R4");
    drive(1, 32'h0000_0C00, 1, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd2, "R4");
    // R4 section, tiny, extended small
    drive(1, 32'h0000_0000, 0, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd3, "R4");
    drive(1, 32'h0000_FC00, 1, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd5, "R4");
    drive(1, 32'h0000_FC00, 1, 1, 0, 0, 32'h10, 4'd2, 12'h030, 3'd5, "R4");
    drive(1, 32'h0000_FC00, 0, 1, 0, 0, 32'h10, 4'd2, 12'h030, 3'd4, "R4");
    // R5 code 0
    drive(1, 0, 1, 0, 1, 0, 32'h10, 4'd2, 12'h000, 3'd5, "R5");
    drive(1, 0, 1, 0, 0, 0, 32'h10, 4'd2, 12'h000, 3'd5, "R5");
    drive(1, 0, 1, 1, 1, 0, 32'h10, 4'd2, 12'h000, 3'd5, "R5");
    drive(1, 0, 1, 1, 0, 1, 32'h10, 4'd2, 12'h000, 3'd5, "R5");
    drive(1, 0, 0, 0, 1, 1, 32'h10, 4'd2, 12'h000, 3'd5, "R5");
    // R6 codes 1..3
    drive(1, 0, 0, 0, 0, 0, 32'h10, 4'd2, 12'h010, 3'd5, "R6");
    drive(1, 0, 1, 1, 0, 0, 32'h10, 4'd2, 12'h010, 3'd5, "R6");
    drive(1, 0, 1, 1, 0, 0, 32'h10, 4'd2, 12'h020, 3'd5, "R6");
    drive(1, 0, 0, 1, 0, 0, 32'h10, 4'd2, 12'h020, 3'd5, "R6");
    drive(1, 0, 0, 0, 0, 0, 32'h10, 4'd2, 12'h020, 3'd5, "R6");
    drive(1, 0, 0, 1, 0, 0, 32'h10, 4'd2, 12'h030, 3'd5, "R6");
    // R7 section versus page refusal
    drive(1, 0, 0, 1, 0, 0, 32'h10, 4'd2, 12'h040, 3'd3, "R7");
    drive(1, 32'h0000_4000, 0, 1, 0, 0, 32'h10, 4'd2, MIX, 3'd2, "R7");
    // R9 idle: no fault, last domain held
    drive(1, 0, 0, 1, 0, 0, 32'h0, 4'd6, 12'h0, 3'd1, "R9");
    drive(0, 0, 0, 1, 0, 0, 32'h0, 4'd9, 12'h0, 3'd1, "R9");
    drive(0, 0, 0, 1, 0, 0, 32'h0, 4'd11, 12'h0, 3'd3, "R9");
    // mixed patterns
    for (int i = 0; i < 60; i++) begin
      drive(1'($urandom), $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), $urandom, 4'($urandom), 12'($urandom),
            3'($urandom_range(0, 5)), "R4");
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule